// File: doc/BRIEF.md
# GPIO Signal Routing Crossbar

This block sits between a bank of general-purpose pads and the internal peripherals of a chip. For every pad, software chooses which signal drives the pad's output level and which signal decides whether the pad is driven at all. For every peripheral input, software chooses which pad, if any, feeds it. The choices are held in selector registers on a simple 32-bit register bus. The block also returns the raw level of every pad as packed status bits.

Selectors are 8-bit lanes packed four to a 32-bit word. A pad's output-source lane and output-enable lane sit in word `pad/4`, at bit `8*(pad%4)`, of their own regions. A peripheral input's lane sits in word `in/4`, at bit `8*(in%4)`, of the input region. For output-enable codes, a small source count means that only the low `OE_BITS` bits of each lane are stored. Input selectors name a pad with an offset of two, so that the two lowest codes can mean fixed levels. After reset every pad is an undriven input with a low output source, and every peripheral input reads low.

The address is split into four regions by its two top bits: 0 output source, 1 output enable, 2 peripheral input select, 3 pad status. The word index comes from `addr[ADDR_W-3:2]`. Reads are combinational from the address. Writes take effect at the rising clock edge while `bus_we` is high.

Top module: `gpio_route_xbar`

## Requirements
- R1: While `rst_n` is low at a clock edge, every output-source selector becomes 0, every output-enable selector becomes 1 and every input selector becomes 0. After that edge `pad_out`, `pad_oe` and `periph_in` are all zero, and the output-enable words read back 0x01010101.
- R2: The output-source selector of pad P is the byte lane at bit `8*(P%4)` of word `P/4` in region 0 (byte address `4*(P/4)`). The output-enable selector of pad P sits at the same lane of region 1 (byte address 0x40 + `4*(P/4)` at the default width).
- R3: Output-source code 0 drives the pad low and code 1 drives it high. Code 2+k drives it with `periph_out[k]` for k below `NUM_PERIPH_OUT`. Any larger code drives it low.
- R4: Output-enable code 0 drives the pad and code 1 leaves it undriven. Code 2+k drives the pad exactly while `periph_oen[k]` is low, for k below `NUM_PERIPH_OE`. Any larger code leaves it undriven.
- R5: Only the low `OE_BITS` (default 6) bits of an output-enable lane are stored. The upper bits of each lane read back as zero and have no effect on the pad.
- R6: Input-select code 0 feeds the peripheral input low and code 1 feeds it high. Code P+2 feeds it with `pad_in[P]` for a pad that exists. Any larger code feeds it low. Input I's lane is at bit `8*(I%4)` of region-2 word `I/4` (byte address 0x80 + `4*(I/4)`).
- R7: A write changes only the byte lanes whose `bus_be` bit is set (`bus_be[j]` covers `wdata[8j+7:8j]`). A write with all strobes clear changes nothing.
- R8: Region 3 word W (byte address 0xC0 + 4W) returns the raw level of pad P at bit `P%32` when `W == P/32`. Writes to region 3 have no effect.
- R9: The following addresses read as zero and ignore writes: a word beyond the end of its region, and an address whose two low bits are not zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_we | input | 1 | Write enable |
| bus_be | input | 4 | Byte strobes for a write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pad_in | input | NUM_PADS | Raw pad input levels |
| pad_out | output | NUM_PADS | Pad output levels |
| pad_oe | output | NUM_PADS | Pad output enables, high = driven |
| periph_out | input | NUM_PERIPH_OUT | Peripheral output signals |
| periph_oen | input | NUM_PERIPH_OE | Peripheral output enables, active low |
| periph_in | output | NUM_PERIPH_IN | Routed peripheral inputs |

## Verification
The assertions assume the following of the inputs: bus controls and peripheral signals are known values whenever reset is high, and `rst_n` is held low across the first clock edge. The stable-selector checks also assume that a write is not counted as having happened unless both `bus_we` and a strobe are high at the edge. The stimulus drives every input from a defined value before reset is released. It changes bus and pad inputs only at falling edges, so the combinational routing has settled before the outputs are sampled. Codes past the last source, masked enable bits, partial strobes and odd addresses are all driven on purpose, so the decode reaches its fall-through paths.

// File: rtl/gpx_pkg.sv
// Package: shared codes and region encoding for the GPIO routing crossbar.
// Assumes: selector lanes are 8 bits wide, packed four per 32-bit word.
package gpx_pkg;
    // Output-source codes
    localparam int SRC_LOW  = 0;
    localparam int SRC_HIGH = 1;
    localparam int SRC_BASE = 2;
    // Output-enable codes
    localparam int OE_DRIVE = 0;
    localparam int OE_FLOAT = 1;
    localparam int OE_BASE  = 2;
    // Input-select codes: pad P is selected by P + PAD_BASE
    localparam int PAD_BASE = 2;
    localparam int LANE_W   = 8;
    localparam int LANES    = 4;

    typedef enum logic [1:0] {
        REG_OUT  = 2'd0,
        REG_OE   = 2'd1,
        REG_IN   = 2'd2,
        REG_STAT = 2'd3
    } region_e;
endpackage

// File: rtl/gpx_regs.sv
// Module: selector register file with byte-strobed writes and combinational readback.
// Assumes: bus inputs are known whenever rst_n is high; NUM_PADS and NUM_PERIPH_IN
// fit the word index range of one region.
module gpx_regs
    import gpx_pkg::*;
#(
    parameter int NUM_PADS      = 16,
    parameter int NUM_PERIPH_IN = 8,
    parameter int OE_BITS       = 6,
    parameter int ADDR_W        = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [ADDR_W-1:0]              bus_addr,
    input  logic                           bus_we,
    input  logic [3:0]                     bus_be,
    input  logic [31:0]                    bus_wdata,
    output logic [31:0]                    bus_rdata,
    input  logic [NUM_PADS-1:0]            pad_in,
    output logic [NUM_PADS*LANE_W-1:0]     out_sel_flat,
    output logic [NUM_PADS*OE_BITS-1:0]    oe_sel_flat,
    output logic [NUM_PERIPH_IN*LANE_W-1:0] in_sel_flat
);
    localparam int WIDX_W     = ADDR_W - 4;
    localparam int OUT_WORDS  = (NUM_PADS + LANES - 1) / LANES;
    localparam int IN_WORDS   = (NUM_PERIPH_IN + LANES - 1) / LANES;
    localparam int STAT_WORDS = (NUM_PADS + 31) / 32;

    // Mask of lane bits above the stored enable code, used by the readback check.
    function automatic logic [31:0] oe_upper_mask();
        logic [31:0] m;
        m = '0;
        for (int l = 0; l < LANES; l++) begin
            for (int b = OE_BITS; b < LANE_W; b++) begin
                m[l*LANE_W + b] = 1'b1;
            end
        end
        return m;
    endfunction
    localparam logic [31:0] OE_UPPER = oe_upper_mask();

    region_e           region;
    logic [WIDX_W-1:0] widx;
    logic              aligned;
    logic              wr_out;
    logic              wr_oe;
    logic              wr_in;

    logic [LANE_W-1:0]  out_sel [NUM_PADS];
    logic [OE_BITS-1:0] oe_sel  [NUM_PADS];
    logic [LANE_W-1:0]  in_sel  [NUM_PERIPH_IN];

    // Split the address into region, word index and alignment flag.
    always_comb begin
        region  = region_e'(bus_addr[ADDR_W-1 -: 2]);
        widx    = bus_addr[ADDR_W-3:2];
        aligned = (bus_addr[1:0] == 2'b00);
        wr_out  = bus_we && aligned && (region == REG_OUT);
        wr_oe   = bus_we && aligned && (region == REG_OE);
        wr_in   = bus_we && aligned && (region == REG_IN);
    end

    for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
        localparam int LN = p % LANES;
        localparam logic [WIDX_W-1:0] WD = WIDX_W'(p / LANES);

        // Hold the output-source selector of one pad.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                out_sel[p] <= LANE_W'(SRC_LOW);
            end else if (wr_out && (widx == WD) && bus_be[LN]) begin
                out_sel[p] <= bus_wdata[LN*LANE_W +: LANE_W];
            end
        end

        // Hold the output-enable selector of one pad, low bits only.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                oe_sel[p] <= OE_BITS'(OE_FLOAT);
            end else if (wr_oe && (widx == WD) && bus_be[LN]) begin
                oe_sel[p] <= bus_wdata[LN*LANE_W +: OE_BITS];
            end
        end

        assign out_sel_flat[p*LANE_W +: LANE_W]  = out_sel[p];
        assign oe_sel_flat[p*OE_BITS +: OE_BITS] = oe_sel[p];
    end

    for (genvar i = 0; i < NUM_PERIPH_IN; i++) begin : g_in
        localparam int LN = i % LANES;
        localparam logic [WIDX_W-1:0] WD = WIDX_W'(i / LANES);

        // Hold the pad selector of one peripheral input.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                in_sel[i] <= '0;
            end else if (wr_in && (widx == WD) && bus_be[LN]) begin
                in_sel[i] <= bus_wdata[LN*LANE_W +: LANE_W];
            end
        end

        assign in_sel_flat[i*LANE_W +: LANE_W] = in_sel[i];
    end

    // Select the read word; missing words and odd addresses return zero.
    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            unique case (region)
                REG_OUT: begin
                    for (int p = 0; p < NUM_PADS; p++) begin
                        if (widx == WIDX_W'(p / LANES)) begin
                            bus_rdata[(p % LANES)*LANE_W +: LANE_W] = out_sel[p];
                        end
                    end
                end
                REG_OE: begin
                    for (int p = 0; p < NUM_PADS; p++) begin
                        if (widx == WIDX_W'(p / LANES)) begin
                            bus_rdata[(p % LANES)*LANE_W +: OE_BITS] = oe_sel[p];
                        end
                    end
                end
                REG_IN: begin
                    for (int i = 0; i < NUM_PERIPH_IN; i++) begin
                        if (widx == WIDX_W'(i / LANES)) begin
                            bus_rdata[(i % LANES)*LANE_W +: LANE_W] = in_sel[i];
                        end
                    end
                end
                REG_STAT: begin
                    for (int p = 0; p < NUM_PADS; p++) begin
                        if (widx == WIDX_W'(p / 32)) begin
                            bus_rdata[p % 32] = pad_in[p];
                        end
                    end
                end
                default: bus_rdata = '0;
            endcase
        end
    end

    // R7
    be_zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_be == 4'b0000) |=>
            ($stable(out_sel_flat) && $stable(oe_sel_flat) && $stable(in_sel_flat)));

    // R8
    stat_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && region == REG_STAT) |=>
            ($stable(out_sel_flat) && $stable(oe_sel_flat) && $stable(in_sel_flat)));

    // R9
    odd_addr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr[1:0] != 2'b00) |-> (bus_rdata == 32'h0));

    // R5
    oe_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (region == REG_OE) |-> ((bus_rdata & OE_UPPER) == 32'h0));

    // R9
    out_gap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (region == REG_OUT && int'(widx) >= OUT_WORDS) |-> (bus_rdata == 32'h0));

    // R9
    in_gap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (region == REG_IN && int'(widx) >= IN_WORDS) |-> (bus_rdata == 32'h0));

    // R9
    stat_gap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (region == REG_STAT && int'(widx) >= STAT_WORDS) |-> (bus_rdata == 32'h0));
endmodule

// File: rtl/gpx_out_route.sv
// Module: per-pad output-value and output-enable source multiplexers.
// Assumes: NUM_PERIPH_OE + OE_BASE fits in OE_BITS; peripheral enables are active low.
module gpx_out_route
    import gpx_pkg::*;
#(
    parameter int NUM_PADS       = 16,
    parameter int NUM_PERIPH_OUT = 8,
    parameter int NUM_PERIPH_OE  = 8,
    parameter int OE_BITS        = 6
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_PADS*LANE_W-1:0]  out_sel_flat,
    input  logic [NUM_PADS*OE_BITS-1:0] oe_sel_flat,
    input  logic [NUM_PERIPH_OUT-1:0]   periph_out,
    input  logic [NUM_PERIPH_OE-1:0]    periph_oen,
    output logic [NUM_PADS-1:0]         pad_out,
    output logic [NUM_PADS-1:0]         pad_oe
);
    for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
        logic [LANE_W-1:0]  ocode;
        logic [OE_BITS-1:0] ecode;

        assign ocode = out_sel_flat[p*LANE_W +: LANE_W];
        assign ecode = oe_sel_flat[p*OE_BITS +: OE_BITS];

        // Pick the pad output level from constants or a peripheral output.
        always_comb begin
            pad_out[p] = 1'b0;
            if (ocode == LANE_W'(SRC_HIGH)) begin
                pad_out[p] = 1'b1;
            end
            for (int k = 0; k < NUM_PERIPH_OUT; k++) begin
                if (ocode == LANE_W'(k + SRC_BASE)) begin
                    pad_out[p] = periph_out[k];
                end
            end
        end

        // Pick the pad drive enable from constants or an active-low peripheral enable.
        always_comb begin
            pad_oe[p] = 1'b0;
            if (ecode == OE_BITS'(OE_DRIVE)) begin
                pad_oe[p] = 1'b1;
            end
            for (int k = 0; k < NUM_PERIPH_OE; k++) begin
                if (ecode == OE_BITS'(k + OE_BASE)) begin
                    pad_oe[p] = !periph_oen[k];
                end
            end
        end

        // R4
        float_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ecode == OE_BITS'(OE_FLOAT)) |-> !pad_oe[p]);

        // R3
        low_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ocode == LANE_W'(SRC_LOW)) |-> !pad_out[p]);

        // R3
        past_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (int'(ocode) >= NUM_PERIPH_OUT + SRC_BASE) |-> !pad_out[p]);
    end
endmodule

// File: rtl/gpx_in_route.sv
// Module: per-peripheral-input pad selector.
// Assumes: NUM_PADS + PAD_BASE fits in an 8-bit lane.
module gpx_in_route
    import gpx_pkg::*;
#(
    parameter int NUM_PADS      = 16,
    parameter int NUM_PERIPH_IN = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_PERIPH_IN*LANE_W-1:0] in_sel_flat,
    input  logic [NUM_PADS-1:0]             pad_in,
    output logic [NUM_PERIPH_IN-1:0]        periph_in
);
    for (genvar i = 0; i < NUM_PERIPH_IN; i++) begin : g_in
        logic [LANE_W-1:0] sel;

        assign sel = in_sel_flat[i*LANE_W +: LANE_W];

        // Feed one peripheral input from a constant or the chosen pad.
        always_comb begin
            periph_in[i] = 1'b0;
            if (sel == LANE_W'(1)) begin
                periph_in[i] = 1'b1;
            end
            for (int p = 0; p < NUM_PADS; p++) begin
                if (sel == LANE_W'(p + PAD_BASE)) begin
                    periph_in[i] = pad_in[p];
                end
            end
        end

        // R6
        const_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (sel == LANE_W'(1)) |-> periph_in[i]);

        // R6
        beyond_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (int'(sel) >= NUM_PADS + PAD_BASE) |-> !periph_in[i]);
    end
endmodule

// File: rtl/gpio_route_xbar.sv
// Module: top of the GPIO routing crossbar; joins the selector registers to the
// output and input routing networks.
// Assumes: synchronous active-low reset held across at least one clock edge.
module gpio_route_xbar
    import gpx_pkg::*;
#(
    parameter int NUM_PADS       = 16,
    parameter int NUM_PERIPH_OUT = 8,
    parameter int NUM_PERIPH_OE  = 8,
    parameter int NUM_PERIPH_IN  = 8,
    parameter int OE_BITS        = 6,
    parameter int ADDR_W         = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic                      bus_we,
    input  logic [3:0]                bus_be,
    input  logic [31:0]               bus_wdata,
    output logic [31:0]               bus_rdata,
    input  logic [NUM_PADS-1:0]       pad_in,
    output logic [NUM_PADS-1:0]       pad_out,
    output logic [NUM_PADS-1:0]       pad_oe,
    input  logic [NUM_PERIPH_OUT-1:0] periph_out,
    input  logic [NUM_PERIPH_OE-1:0]  periph_oen,
    output logic [NUM_PERIPH_IN-1:0]  periph_in
);
    logic [NUM_PADS*LANE_W-1:0]      out_sel_flat;
    logic [NUM_PADS*OE_BITS-1:0]     oe_sel_flat;
    logic [NUM_PERIPH_IN*LANE_W-1:0] in_sel_flat;

    gpx_regs #(
        .NUM_PADS      (NUM_PADS),
        .NUM_PERIPH_IN (NUM_PERIPH_IN),
        .OE_BITS       (OE_BITS),
        .ADDR_W        (ADDR_W)
    ) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_addr     (bus_addr),
        .bus_we       (bus_we),
        .bus_be       (bus_be),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .pad_in       (pad_in),
        .out_sel_flat (out_sel_flat),
        .oe_sel_flat  (oe_sel_flat),
        .in_sel_flat  (in_sel_flat)
    );

    gpx_out_route #(
        .NUM_PADS       (NUM_PADS),
        .NUM_PERIPH_OUT (NUM_PERIPH_OUT),
        .NUM_PERIPH_OE  (NUM_PERIPH_OE),
        .OE_BITS        (OE_BITS)
    ) u_out (
        .clk          (clk),
        .rst_n        (rst_n),
        .out_sel_flat (out_sel_flat),
        .oe_sel_flat  (oe_sel_flat),
        .periph_out   (periph_out),
        .periph_oen   (periph_oen),
        .pad_out      (pad_out),
        .pad_oe       (pad_oe)
    );

    gpx_in_route #(
        .NUM_PADS      (NUM_PADS),
        .NUM_PERIPH_IN (NUM_PERIPH_IN)
    ) u_in (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_sel_flat (in_sel_flat),
        .pad_in      (pad_in),
        .periph_in   (periph_in)
    );

    // R1
    reset_float_chk: assert property (@(posedge clk)
        !rst_n |=> (pad_oe == '0 && pad_out == '0 && periph_in == '0));
endmodule

// File: tb/tb_gpio_route_xbar.sv
module tb_gpio_route_xbar;
    localparam int NP = 16;
    localparam logic [7:0] OUT_B  = 8'h00;
    localparam logic [7:0] OE_B   = 8'h40;
    localparam logic [7:0] IN_B   = 8'h80;
    localparam logic [7:0] STAT_B = 8'hC0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NP-1:0] pad_in = '0;
    logic [NP-1:0] pad_out;
    logic [NP-1:0] pad_oe;
    logic [7:0]  periph_out = '0;
    logic [7:0]  periph_oen = '1;
    logic [7:0]  periph_in;

    int checks = 0;
    int fails = 0;

    always #4 clk = ~clk;

    gpio_route_xbar dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .periph_out(periph_out), .periph_oen(periph_oen), .periph_in(periph_in)
    );

    typedef struct packed {
        logic [3:0] pad;
        logic [7:0] ocode;
        logic [7:0] ecode;
        logic [7:0] pout;
        logic [7:0] poen;
        logic       eout;
        logic       eoe;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{4'd0,  8'h01, 8'h00, 8'h00, 8'hFF, 1'b1, 1'b1},
        '{4'd5,  8'h00, 8'h00, 8'hFF, 8'hFF, 1'b0, 1'b1},
        '{4'd7,  8'h05, 8'h01, 8'h08, 8'h00, 1'b1, 1'b0},
        '{4'd10, 8'h05, 8'h04, 8'hF7, 8'hFB, 1'b0, 1'b1},
        '{4'd13, 8'h09, 8'h04, 8'h80, 8'h04, 1'b1, 1'b0},
        '{4'd15, 8'h0A, 8'h0A, 8'hFF, 8'h00, 1'b0, 1'b0},
        '{4'd3,  8'h01, 8'h41, 8'h00, 8'hFF, 1'b1, 1'b0},
        '{4'd12, 8'hFF, 8'hC0, 8'hFF, 8'hFF, 1'b0, 1'b1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_be = be; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; bus_be = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 pad_oe", 32'(pad_oe), 32'h0);
        chk("R1 pad_out", 32'(pad_out), 32'h0);
        chk("R1 periph_in", 32'(periph_in), 32'h0);
        rd(OE_B, r);       chk("R1 oe word", r, 32'h01010101);
        rd(OUT_B, r);      chk("R1 out word", r, 32'h0);
        rd(IN_B, r);       chk("R1 in word", r, 32'h0);

        // R2 R3 R4 R5 R7: table walk, one lane written per word with garbage elsewhere
        for (int i = 0; i < 8; i++) begin
            int ln;
            logic [7:0] wa;
            logic [31:0] d;
            ln = int'(VECS[i].pad) % 4;
            wa = 8'(4 * (int'(VECS[i].pad) / 4));
            periph_out = VECS[i].pout;
            periph_oen = VECS[i].poen;
            d = 32'hEEEEEEEE;
            d[8*ln +: 8] = VECS[i].ocode;
            wr(OUT_B + wa, 4'(1 << ln), d);
            d = 32'hEEEEEEEE;
            d[8*ln +: 8] = VECS[i].ecode;
            wr(OE_B + wa, 4'(1 << ln), d);
            #1;
            chk("R3 pad_out", 32'(pad_out[VECS[i].pad]), 32'(VECS[i].eout));
            chk("R4 pad_oe", 32'(pad_oe[VECS[i].pad]), 32'(VECS[i].eoe));
        end

        // R2 R7 lane placement and untouched lanes
        rd(OUT_B + 8'h00, r); chk("R2 out w0", r, 32'h01000001);
        rd(OUT_B + 8'h04, r); chk("R2 out w1", r, 32'h05000000);
        rd(OUT_B + 8'h08, r); chk("R2 out w2", r, 32'h00050000);
        rd(OUT_B + 8'h0C, r); chk("R2 out w3", r, 32'h0A0009FF);
        // R5 enable lanes keep only the low bits
        rd(OE_B + 8'h00, r);  chk("R5 oe w0", r, 32'h01010100);
        rd(OE_B + 8'h0C, r);  chk("R5 oe w3", r, 32'h0A010400);

        // R6 input routing
        pad_in = 16'hA5A5;
        wr(IN_B, 4'hF, 32'h03070100);
        wr(IN_B + 8'h04, 4'hF, 32'hFF021211);
        #1 chk("R6 periph_in A5A5", 32'(periph_in), 32'h56);
        @(negedge clk);
        pad_in = 16'h5A5A;
        #1 chk("R6 periph_in 5A5A", 32'(periph_in), 32'h0A);

        // R8 status word
        rd(STAT_B, r); chk("R8 status", r, 32'h00005A5A);
        wr(STAT_B, 4'hF, 32'hFFFFFFFF);
        rd(STAT_B, r); chk("R8 status after write", r, 32'h00005A5A);
        rd(IN_B, r);   chk("R8 in sel kept", r, 32'h03070100);

        // R7 partial strobe and empty strobe
        wr(IN_B + 8'h04, 4'b0010, 32'hAAAA03AA);
        rd(IN_B + 8'h04, r); chk("R7 partial", r, 32'hFF020311);
        #1 chk("R7 periph_in", 32'(periph_in), 32'h2A);
        wr(IN_B, 4'b0000, 32'h0);
        rd(IN_B, r); chk("R7 no strobe", r, 32'h03070100);

        // R9 unmapped and misaligned
        rd(OUT_B + 8'h10, r); chk("R9 out gap", r, 32'h0);
        rd(IN_B + 8'h08, r);  chk("R9 in gap", r, 32'h0);
        rd(STAT_B + 8'h04, r); chk("R9 stat gap", r, 32'h0);
        rd(8'h02, r);         chk("R9 odd read", r, 32'h0);
        wr(8'h01, 4'hF, 32'h0);
        rd(OUT_B, r);         chk("R9 odd write", r, 32'h01000001);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule